// File: doc/BRIEF.md
# Watchdog Control with Timed Disable

This block holds a watchdog control register and the timeout counter it governs. Software reaches the register through a one-cycle write strobe with an 8-bit data word and reads it back on a combinational read bus. When the watchdog runs, it counts pulses on a base tick input. A kick pulse restarts the count. If the count reaches the timeout chosen by the three scale bits, the block raises a one-cycle reset request and starts counting again.

Turning the watchdog off is protected. A write can clear the enable bit only while an unlock bit is set. Hardware drops that unlock bit by itself four cycles after the write that set it. Software must therefore write unlock and enable together as ones, then clear enable in one of the next four cycles. A stray write cannot stop the watchdog.

Top module: `wdog_ctl`

## Requirements
- R1: After synchronous reset, every register bit reads zero and the reset request output is low.
- R2: The read bus returns {3'b000, unlock, enable, scale[2:0]}: bit 4 is unlock, bit 3 is enable, bits 2:0 are the scale. Bits 7:5 always read zero, whatever was written to them.
- R3: A write with bit 3 at one sets enable. A write with bit 3 at zero leaves enable unchanged while unlock is zero. The scale bits of every write take effect in either case.
- R4: A write with bit 4 at one sets unlock. It reads one for the four cycles after that write's clock edge and is cleared by hardware at the fourth following edge. A write with bit 4 at zero clears unlock at once.
- R5: A write with bit 3 at zero clears enable when its clock edge is one of the four edges that follow an unlock-setting write. At the fifth edge it no longer does.
- R6: Once enabled with ticks on every cycle, the first reset request appears exactly 2^(BASE_EXP+scale) ticks after the enabling edge, for each of the eight scale values.
- R7: The reset request lasts one cycle, and the count restarts from zero so that requests repeat with the same period.
- R8: A kick clears the count. A kick in the same cycle as the tick that would expire the count suppresses that request, and a full period follows.
- R9: While disabled, no reset request is raised and the count is held at zero, so re-enabling always gives a full period.
- R10: The count advances only in cycles where the tick input is high.
- R11: If the scale is lowered below the current count, the next tick expires the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| tick | input | 1 | Base tick enable for the counter |
| kick | input | 1 | Counter restart pulse |
| reset_req | output | 1 | One-cycle watchdog expiry request |

## Verification
Two pairs of functions can meet on one edge. The first pair is a kick and the tick that would expire the count. The bench raises kick on exactly the expiring edge and expects no request, then a full fresh period. The second pair is a disabling write and the end of the unlock window. The bench places the clearing write zero to four cycles after the unlock write and expects enable to be cleared for the first four placements only.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int WD_PS_W          = 3;
    localparam int WD_DEF_BASE_EXP  = 14;
    localparam int WD_WIN_CYC       = 4;

    typedef struct packed {
        logic [2:0]         rsvd;
        logic               unlock;
        logic               enable;
        logic [WD_PS_W-1:0] scale;
    } wd_csr_t;

    function automatic wd_csr_t wd_pack(input logic unlock,
                                        input logic enable,
                                        input logic [WD_PS_W-1:0] scale);
        wd_csr_t r;
        r.rsvd   = 3'b000;
        r.unlock = unlock;
        r.enable = enable;
        r.scale  = scale;
        return r;
    endfunction

endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock #(
    parameter int WIN_CYC = wdog_pkg::WD_WIN_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_unlock,
    output logic armed
);
    localparam int WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_CYC - 1);

    logic [WIN_W-1:0] win_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            win_left <= '0;
        end else if (wr_en) begin
            armed    <= wr_unlock;
            win_left <= WIN_LOAD;
        end else if (armed) begin
            if (win_left == '0) armed <= 1'b0;
            else                win_left <= win_left - 1'b1;
        end
    end

    AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_unlock |=> armed); // R4
    AST_ARM_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !armed && !wr_en |=> !armed); // R4
endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  wd_csr_t            wr_word,
    input  logic               armed,
    output logic               enable,
    output logic [WD_PS_W-1:0] scale
);
    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            scale  <= '0;
        end else if (wr_en) begin
            scale <= wr_word.scale;
            if (wr_word.enable) enable <= 1'b1;
            else if (armed)     enable <= 1'b0;
        end
    end

    AST_SET_ENABLE: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_word.enable |=> enable); // R3
    AST_LOCKED_ENABLE: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_word.enable && !armed && enable |=> enable); // R3
    AST_UNLOCKED_CLEAR: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_word.enable && armed |=> !enable); // R5
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(enable) && $stable(scale)); // R2
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int BASE_EXP = WD_DEF_BASE_EXP
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               tick,
    input  logic               kick,
    input  logic [WD_PS_W-1:0] scale,
    output logic               bite
);
    localparam int CNT_W = BASE_EXP + (1 << WD_PS_W) - 1;

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] last_val;
    logic             expire;

    always_comb begin
        last_val = (CNT_W'(1) << (BASE_EXP + int'(scale))) - CNT_W'(1);
        expire   = enable && tick && !kick && (count >= last_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            bite  <= 1'b0;
        end else begin
            bite <= expire;
            if (!enable || kick || expire) count <= '0;
            else if (tick)                 count <= count + 1'b1;
        end
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        bite |=> !bite); // R7
    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !bite); // R9
    AST_KICK_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
        kick |=> !bite); // R8
    AST_NO_TICK_NO_BITE: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !bite); // R10
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
    import wdog_pkg::*;
#(
    parameter int BASE_EXP = WD_DEF_BASE_EXP,
    parameter int WIN_CYC  = WD_WIN_CYC
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       tick,
    input  logic       kick,
    output logic       reset_req
);
    wd_csr_t            wr_word;
    logic               armed;
    logic               enable;
    logic [WD_PS_W-1:0] scale;
    logic               unused_rsvd;

    assign wr_word     = wd_csr_t'(wr_data);
    assign unused_rsvd = ^wr_word.rsvd;
    assign rd_data     = wd_pack(armed, enable, scale);

    wdog_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_unlock (wr_word.unlock),
        .armed     (armed)
    );

    wdog_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .armed   (armed),
        .enable  (enable),
        .scale   (scale)
    );

    wdog_timer #(.BASE_EXP(BASE_EXP)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .tick   (tick),
        .kick   (kick),
        .scale  (scale),
        .bite   (reset_req)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> rd_data == 8'h00 && !reset_req); // R1
endmodule

// File: tb/wdog_ctl_tb.sv
module wdog_ctl_tb;
    localparam int BEXP = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tick = 1'b1;
    logic       kick = 1'b0;
    logic       reset_req;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    wdog_ctl #(.BASE_EXP(BEXP)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick(tick), .kick(kick), .reset_req(reset_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // entered and left at a falling edge
    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic do_reset();
        rst = 1'b1; kick = 1'b0; tick = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // edges until the next reset request, capped
    task automatic edges_to_bite(input int cap, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!reset_req && n < cap);
    endtask

    initial begin
        int n;
        int bites;
        @(negedge clk);
        do_reset();
        check("R1 reset read", rd_data, 8'h00);
        check("R1 reset request", reset_req, 0);

        // R2: reserved bits read zero
        wr(8'hEB);
        check("R2 reserved zero", rd_data, 8'h0B);
        wr(8'h0D);
        // R3: locked write of zero keeps enable, scale updates
        wr(8'h05);
        check("R3 locked enable kept", rd_data, 8'h0D);
        // R3: unlock write with enable zero while locked keeps enable
        wr(8'h10);
        check("R3 unlock write enable zero", rd_data, 8'h18);
        // R4: explicit clear of unlock
        wr(8'h08);
        check("R4 unlock cleared by write", rd_data, 8'h08);
        wr(8'h00);
        check("R4 relocked enable kept", rd_data, 8'h08);
        // R1: reset mid-operation
        do_reset();
        check("R1 reset clears state", rd_data, 8'h00);

        // R4: unlock lifetime
        wr(8'h18);
        for (int i = 0; i < 6; i++) begin
            check($sformatf("R4 unlock window cycle %0d", i), rd_data[4], (i < 4) ? 1 : 0);
            @(negedge clk);
        end

        // R5: disabling write at each placement in/after the window
        for (int gap = 0; gap < 5; gap++) begin
            do_reset();
            wr(8'h08);
            wr(8'h18);
            repeat (gap) @(negedge clk);
            wr(8'h00);
            check($sformatf("R5 disable gap %0d", gap), rd_data[3], (gap < 4) ? 0 : 1);
        end

        // R6/R7: timeout for every scale, twice
        for (int p = 0; p < 8; p++) begin
            int lim;
            lim = 1 << (BEXP + p);
            do_reset();
            wr(8'h08 | 8'(p));
            edges_to_bite(lim + 8, n);
            check($sformatf("R6 first period scale %0d", p), n, lim);
            @(negedge clk);
            check($sformatf("R7 pulse width scale %0d", p), reset_req, 0);
            edges_to_bite(lim + 8, n);
            check($sformatf("R7 second period scale %0d", p), n + 1, lim);
        end

        // R8: kick on the expiring edge
        do_reset();
        wr(8'h08);
        repeat (3) @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        check("R8 kick on expiry suppresses", reset_req, 0);
        edges_to_bite(20, n);
        check("R8 full period after collision kick", n, 4);
        // R8: early kick
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        edges_to_bite(20, n);
        check("R8 period after early kick", n, 4);

        // R10: no ticks, no advance
        do_reset();
        wr(8'h08);
        tick = 1'b0;
        bites = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (reset_req) bites++;
        end
        check("R10 no bite without ticks", bites, 0);
        tick = 1'b1;
        edges_to_bite(20, n);
        check("R10 count held while tick low", n, 4);

        // R9: disabled gives no request; re-enable full period
        do_reset();
        wr(8'h08);
        @(negedge clk);
        @(negedge clk);
        wr(8'h18);
        wr(8'h00);
        bites = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (reset_req) bites++;
        end
        check("R9 disabled no bite", bites, 0);
        wr(8'h08);
        edges_to_bite(20, n);
        check("R9 full period after re-enable", n, 4);

        // R11: lowering the scale below the count
        do_reset();
        wr(8'h0F);
        repeat (100) @(negedge clk);
        check("R11 no early bite", reset_req, 0);
        wr(8'h08);
        @(negedge clk);
        check("R11 immediate expiry after scale drop", reset_req, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule